// File: doc/BRIEF.md
# Nibble-Mode Reverse Channel Transmitter

This block sits on the peripheral side of a parallel host link. It takes bytes from an upstream source through a valid/ready interface and sends each one to the host as two four-bit halves on four status lines. The low half goes first. Every half is paced by a two-wire handshake. The host's auto-feed line (`host_feed_n`) says when the host can take data. The peripheral's acknowledge line (`link_ack_n`) marks the half on the status lines as valid.

The block does nothing until the mode-negotiation logic raises `mode_grant`. With the grant held, there are two ways a byte can start. If the host is not parked waiting, the block flags that data is available and waits for the host to ask. If the host is parked with auto-feed low and a byte then arrives, the block first sends a data-available interrupt: fault goes low and acknowledge gives one pulse of a set width. It then waits for the host to raise auto-feed, answers on the paper line, and starts the transfer when the host lowers auto-feed again.

Host lines pass through a synchronizer before the state machine sees them. The status and acknowledge outputs are driven straight from registers.

Top module: `nibble_rev_tx`

## Requirements
- R1: While reset is asserted, `link_ack_n`, `stat_fault_n`, `stat_sel`, `stat_paper` and `stat_busy` are all 1, and `src_ready` is 0.
- R2: While `mode_grant` is 0, the following hold:
  - `link_ack_n`, `stat_fault_n`, `stat_sel` and `stat_paper` stay 1.
  - `stat_busy` follows `fwd_busy` one cycle later.
  - A byte offered on the source side is not taken.
- R3: A byte can be offered while granted, with the host's auto-feed high and no transfer running. In that case `stat_fault_n` and `stat_paper` both go to 0 and stay there until the host lowers auto-feed.
- R4: Each byte goes out low half first, then high half. Within a half, bit 0 is `stat_fault_n`, bit 1 is `stat_sel`, bit 2 is `stat_paper` and bit 3 is `stat_busy`. The half is on those lines at least one cycle before `link_ack_n` falls, and it does not change while `link_ack_n` is low.
- R5: Within a byte, the handshake runs as follows:
  - `link_ack_n` falls only after the host has lowered auto-feed.
  - It rises again after the host raises auto-feed.
  - The second half does not start while auto-feed stays high.
- R6: `src_ready` is high for exactly one cycle per byte. That cycle comes only after the host has confirmed the second half, and `src_ready` stays 0 after the first half.
- R7: After the second half is released, `link_ack_n` is 1 and `stat_busy` equals `fwd_busy`. `stat_fault_n` and `stat_paper` are 0 if another byte is already offered, and 1 otherwise.
- R8: Suppose the host holds auto-feed low with no byte pending, and a byte then arrives. `stat_fault_n` goes to 0 and `link_ack_n` is driven low for exactly `PULSE_CYC` cycles, then returns to 1.
- R9: After that interrupt pulse, `stat_paper` stays 1 until the host raises auto-feed, and then goes to 0. The next lowering of auto-feed starts the byte transfer.
- R10: Pulses on `host_stb_n` have no effect. They do not latch data, do not move `link_ack_n`, and do not change the half on the status lines.
- R11: If `mode_grant` drops in the middle of a byte, the following happen:
  - The block returns `link_ack_n` and the status lines to their idle values of R2 on the next cycle.
  - It raises no `src_ready`.
  - It sends the whole byte again once the grant returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_grant | input | 1 | Nibble mode granted by the negotiation logic (synchronous) |
| src_valid | input | 1 | Upstream byte is offered |
| src_byte | input | 8 | Byte to send |
| src_ready | output | 1 | One-cycle pulse: byte fully delivered and consumed |
| host_feed_n | input | 1 | Host auto-feed line; low means the host can accept data |
| host_stb_n | input | 1 | Host strobe line; ignored in this phase |
| fwd_busy | input | 1 | Forward-channel busy state to show on the busy line |
| link_ack_n | output | 1 | Peripheral acknowledge line |
| stat_fault_n | output | 1 | Status line: fault, nibble bit 0 |
| stat_sel | output | 1 | Status line: select, nibble bit 1 |
| stat_paper | output | 1 | Status line: paper error, nibble bit 2 |
| stat_busy | output | 1 | Status line: busy, nibble bit 3 |

## Verification
The assertions rely on three things about the inputs:
- The upstream source holds `src_valid` and `src_byte` steady until the one-cycle `src_ready` pulse.
- `mode_grant` is synchronous to `clk`.
- The host lines change slowly compared with the synchronizer depth, so the state machine sees each auto-feed level for at least a cycle.

The stimulus drives every input on the falling clock edge. The source model removes `src_valid` in the same edge where `src_ready` is high. The host model changes auto-feed only after it has seen the matching level on `link_ack_n`. Strobe pulses are kept two cycles wide, so they reach the synchronized side.

// File: rtl/nrt_pkg.sv
package nrt_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_AVAIL    = 3'd2,
    ST_IRQ_LOW  = 3'd3,
    ST_IRQ_WAIT = 3'd4,
    ST_SETUP    = 3'd5,
    ST_ACK_LOW  = 3'd6,
    ST_GAP      = 3'd7
  } nrt_state_e;

  typedef struct packed {
    logic ack_n;
    logic busy;
    logic paper;
    logic sel;
    logic fault_n;
  } nrt_lines_t;

  // Place a half-byte on the status lines: bit0 fault, bit1 select,
  // bit2 paper, bit3 busy.
  function automatic nrt_lines_t nrt_nibble(input logic ack_n, input logic [3:0] nib);
    nrt_lines_t l;
    l.ack_n   = ack_n;
    l.fault_n = nib[0];
    l.sel     = nib[1];
    l.paper   = nib[2];
    l.busy    = nib[3];
    return l;
  endfunction

endpackage

// File: rtl/nrt_rst_sync.sv
module nrt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nrt_sync.sv
module nrt_sync #(
  parameter int         W       = 2,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/nrt_timer.sv
module nrt_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  assign done = (cnt_q == limit - W'(1));

  always_comb begin
    if (clr)       cnt_d = '0;
    else if (done) cnt_d = cnt_q;
    else           cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/nrt_fsm.sv
module nrt_fsm
  import nrt_pkg::*;
#(
  parameter int PULSE_CYC = 6,
  parameter int SETUP_CYC = 1,
  parameter int TW        = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       feed_s,
  input  logic       strobe_s,
  input  logic       fwd_busy,
  output logic       in_ready,
  output nrt_lines_t lines
);
  nrt_state_e st_q, st_d;
  logic       nib_hi_q, nib_hi_d;
  logic [7:0] hold_q, hold_d;
  logic       hold_en;
  nrt_lines_t lines_q, lines_d;
  logic [3:0] nib_d;
  logic       xfer_q;

  logic          tmr_clr, tmr_done;
  logic [TW-1:0] tmr_limit, tmr_cnt;

  assign tmr_limit = (st_q == ST_IRQ_LOW) ? TW'(PULSE_CYC) : TW'(SETUP_CYC);
  assign tmr_clr   = (st_d != st_q);

  nrt_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .limit (tmr_limit),
    .cnt   (tmr_cnt),
    .done  (tmr_done)
  );

  // next state
  always_comb begin
    st_d     = st_q;
    nib_hi_d = nib_hi_q;
    hold_en  = 1'b0;
    in_ready = 1'b0;
    case (st_q)
      ST_OFF:      st_d = ST_IDLE;
      ST_IDLE:     if (in_valid) st_d = feed_s ? ST_AVAIL : ST_IRQ_LOW;
      ST_AVAIL: begin
        if (!feed_s) begin
          st_d     = ST_SETUP;
          hold_en  = 1'b1;
          nib_hi_d = 1'b0;
        end
      end
      ST_IRQ_LOW:  if (tmr_done) st_d = ST_IRQ_WAIT;
      ST_IRQ_WAIT: if (feed_s) st_d = ST_AVAIL;
      ST_SETUP:    if (tmr_done) st_d = ST_ACK_LOW;
      ST_ACK_LOW: begin
        if (feed_s) begin
          if (nib_hi_q) begin
            st_d     = ST_IDLE;
            in_ready = 1'b1;
          end else begin
            st_d = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (!feed_s) begin
          st_d     = ST_SETUP;
          nib_hi_d = 1'b1;
        end
      end
      default:     st_d = ST_OFF;
    endcase
    if (!grant) begin
      st_d     = ST_OFF;
      in_ready = 1'b0;
      hold_en  = 1'b0;
      nib_hi_d = 1'b0;
    end
  end

  assign hold_d = hold_en ? in_data : hold_q;
  assign nib_d  = nib_hi_d ? hold_d[7:4] : hold_d[3:0];

  // output decode from the next state, so lines_q tracks st_q
  always_comb begin
    lines_d.ack_n   = 1'b1;
    lines_d.busy    = fwd_busy;
    lines_d.paper   = 1'b1;
    lines_d.sel     = 1'b1;
    lines_d.fault_n = 1'b1;
    case (st_d)
      ST_AVAIL: begin
        lines_d.fault_n = 1'b0;
        lines_d.paper   = 1'b0;
      end
      ST_IRQ_LOW: begin
        lines_d.ack_n   = 1'b0;
        lines_d.fault_n = 1'b0;
      end
      ST_IRQ_WAIT: lines_d.fault_n = 1'b0;
      ST_SETUP,
      ST_GAP:      lines_d = nrt_nibble(1'b1, nib_d);
      ST_ACK_LOW:  lines_d = nrt_nibble(1'b0, nib_d);
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_OFF;
      nib_hi_q <= 1'b0;
      lines_q  <= '1;
    end else begin
      st_q     <= st_d;
      nib_hi_q <= nib_hi_d;
      lines_q  <= lines_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign lines  = lines_q;
  assign xfer_q = (st_q == ST_SETUP) || (st_q == ST_ACK_LOW) || (st_q == ST_GAP);

  // R6
  rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R8
  irq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IRQ_LOW) |-> (tmr_cnt < TW'(PULSE_CYC)));

  // R11
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> (st_q == ST_OFF && lines_q.ack_n && !in_ready));

  // R10
  strobe_blind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_q && !$stable(strobe_s)) |=> $stable(hold_q));

  // R4
  setup_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lines_q.ack_n) && st_q == ST_ACK_LOW)
      |-> $stable({lines_q.busy, lines_q.paper, lines_q.sel, lines_q.fault_n}));

  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lines_q.ack_n) && st_q == ST_GAP) |-> $past(feed_s));

endmodule

// File: rtl/nibble_rev_tx.sv
module nibble_rev_tx
  import nrt_pkg::*;
#(
  parameter int PULSE_CYC   = 6,
  parameter int SETUP_CYC   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_grant,
  input  logic       src_valid,
  input  logic [7:0] src_byte,
  output logic       src_ready,
  input  logic       host_feed_n,
  input  logic       host_stb_n,
  input  logic       fwd_busy,
  output logic       link_ack_n,
  output logic       stat_fault_n,
  output logic       stat_sel,
  output logic       stat_paper,
  output logic       stat_busy
);
  localparam int MAX_CYC = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);

  logic       rst_core_n;
  logic [1:0] host_s;
  nrt_lines_t lines;

  nrt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  nrt_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({host_stb_n, host_feed_n}),
    .q     (host_s)
  );

  nrt_fsm #(.PULSE_CYC(PULSE_CYC), .SETUP_CYC(SETUP_CYC), .TW(TW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .grant    (mode_grant),
    .in_valid (src_valid),
    .in_data  (src_byte),
    .feed_s   (host_s[0]),
    .strobe_s (host_s[1]),
    .fwd_busy (fwd_busy),
    .in_ready (src_ready),
    .lines    (lines)
  );

  assign link_ack_n   = lines.ack_n;
  assign stat_fault_n = lines.fault_n;
  assign stat_sel     = lines.sel;
  assign stat_paper   = lines.paper;
  assign stat_busy    = lines.busy;
endmodule

// File: tb/nibble_rev_tx_test.sv
module nibble_rev_tx_test;
  localparam int PULSE = 6;
  // {byte[7:0], use_interrupt, fwd_busy}
  localparam logic [9:0] VEC [8] = '{
    {8'hA5, 1'b0, 1'b0}, {8'h00, 1'b0, 1'b1}, {8'hFF, 1'b1, 1'b0}, {8'h5A, 1'b1, 1'b1},
    {8'h3C, 1'b0, 1'b1}, {8'h81, 1'b1, 1'b0}, {8'h0F, 1'b0, 1'b0}, {8'hF0, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, mode_grant, src_valid, src_ready, host_feed_n, host_stb_n, fwd_busy;
  logic [7:0] src_byte;
  logic link_ack_n, stat_fault_n, stat_sel, stat_paper, stat_busy;
  int n_chk = 0, n_fail = 0, rdy_cnt = 0;
  bit finished = 0;

  nibble_rev_tx #(.PULSE_CYC(PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .mode_grant(mode_grant), .src_valid(src_valid),
    .src_byte(src_byte), .src_ready(src_ready), .host_feed_n(host_feed_n),
    .host_stb_n(host_stb_n), .fwd_busy(fwd_busy), .link_ack_n(link_ack_n),
    .stat_fault_n(stat_fault_n), .stat_sel(stat_sel), .stat_paper(stat_paper),
    .stat_busy(stat_busy)
  );

  always @(negedge clk) if (src_ready) rdy_cnt++;
  always @(posedge clk) if (src_valid && src_ready) src_valid <= 1'b0;

  function automatic logic [3:0] nib_now();
    return {stat_busy, stat_paper, stat_sel, stat_fault_n};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_ack(input logic v, input string req, output logic [3:0] prev);
    int t = 0;
    prev = nib_now();
    while (link_ack_n !== v && t < 300) begin
      prev = nib_now();
      @(negedge clk);
      t++;
    end
    if (t >= 300) chk({req, " ack timeout"}, link_ack_n, v);
  endtask

  task automatic present(input logic [7:0] d);
    @(negedge clk);
    src_byte  = d;
    src_valid = 1'b1;
  endtask

  task automatic host_read(output logic [7:0] b, input bit poke);
    logic [3:0] lo, hi, pv;
    int r0;
    r0 = rdy_cnt;
    host_feed_n = 1'b0;
    wait_ack(1'b0, "R5", pv);
    lo = nib_now();
    chk("R4 low half set up before ack", pv, lo);
    if (poke) begin
      repeat (4) begin
        host_stb_n = 1'b0; repeat (2) @(negedge clk);
        host_stb_n = 1'b1; repeat (2) @(negedge clk);
      end
      chk("R10 ack held under strobe", link_ack_n, 0);
      chk("R10 half held under strobe", nib_now(), lo);
    end
    host_feed_n = 1'b1;
    wait_ack(1'b1, "R5", pv);
    repeat (10) @(negedge clk);
    chk("R5 second half waits for feed low", link_ack_n, 1);
    chk("R6 no ready after first half", rdy_cnt - r0, 0);
    host_feed_n = 1'b0;
    wait_ack(1'b0, "R5", pv);
    hi = nib_now();
    chk("R4 high half set up before ack", pv, hi);
    host_feed_n = 1'b1;
    wait_ack(1'b1, "R5", pv);
    @(negedge clk);
    chk("R6 one ready pulse per byte", rdy_cnt - r0, 1);
    b = {hi, lo};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] got, d;
    logic [3:0] pv;
    int cnt, r0;
    rst_n = 1'b0; mode_grant = 1'b0; src_valid = 1'b0; src_byte = '0;
    host_feed_n = 1'b1; host_stb_n = 1'b1; fwd_busy = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 ack", link_ack_n, 1);
    chk("R1 lines", nib_now(), 4'hF);
    chk("R1 ready", src_ready, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R2
    chk("R2 busy follows 0", stat_busy, 0);
    fwd_busy = 1'b1; repeat (2) @(negedge clk);
    chk("R2 busy follows 1", stat_busy, 1);
    present(8'hC3);
    repeat (8) @(negedge clk);
    chk("R2 fault idle", stat_fault_n, 1);
    chk("R2 ack idle", link_ack_n, 1);
    chk("R2 byte not taken", rdy_cnt, 0);
    mode_grant = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 fault low on offer", stat_fault_n, 0);
    host_read(got, 0);
    chk("R2 held byte delivered", got, 8'hC3);

    for (int i = 0; i < 8; i++) begin
      d = VEC[i][9:2];
      fwd_busy = VEC[i][0];
      if (VEC[i][1]) begin
        host_feed_n = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8 idle before data", stat_fault_n, 1);
        present(d);
        wait_ack(1'b0, "R8", pv);
        chk("R8 fault low in interrupt", stat_fault_n, 0);
        cnt = 0;
        while (link_ack_n == 1'b0 && cnt < 100) begin cnt++; @(negedge clk); end
        chk("R8 pulse width", cnt, PULSE);
        repeat (3) @(negedge clk);
        chk("R9 paper high before host ack", stat_paper, 1);
        host_feed_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 paper low after host ack", stat_paper, 0);
      end else begin
        present(d);
        repeat (6) @(negedge clk);
        chk("R3 fault low", stat_fault_n, 0);
        chk("R3 paper low", stat_paper, 0);
      end
      host_read(got, 0);
      chk("R4 byte reassembled", got, d);
      repeat (6) @(negedge clk);
      chk("R7 fault idle", stat_fault_n, 1);
      chk("R7 paper idle", stat_paper, 1);
      chk("R7 busy shows forward state", stat_busy, VEC[i][0]);
      chk("R7 ack high", link_ack_n, 1);
    end

    // R7 back to back: next byte offered right after ready
    present(8'h69);
    r0 = rdy_cnt;
    fork
      begin
        wait (rdy_cnt == r0 + 1);
        @(negedge clk);
        src_byte = 8'h96; src_valid = 1'b1;
      end
    join_none
    repeat (6) @(negedge clk);
    host_read(got, 0);
    chk("R4 first of pair", got, 8'h69);
    repeat (6) @(negedge clk);
    chk("R7 fault shows next byte", stat_fault_n, 0);
    chk("R7 paper shows next byte", stat_paper, 0);
    host_read(got, 0);
    chk("R4 second of pair", got, 8'h96);

    // R10 strobe pulses during a transfer
    present(8'h4B);
    repeat (6) @(negedge clk);
    host_read(got, 1);
    chk("R10 byte intact", got, 8'h4B);

    // R11 grant withdrawn mid-byte
    present(8'hE2);
    repeat (6) @(negedge clk);
    r0 = rdy_cnt;
    host_feed_n = 1'b0;
    wait_ack(1'b0, "R11", pv);
    mode_grant = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 ack idle", link_ack_n, 1);
    chk("R11 fault/sel/paper idle", {stat_paper, stat_sel, stat_fault_n}, 3'b111);
    fwd_busy = 1'b0; repeat (2) @(negedge clk);
    chk("R2 busy follows while ungranted", stat_busy, 0);
    host_feed_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R11 no ready", rdy_cnt - r0, 0);
    chk("R11 byte still offered", src_valid, 1);
    mode_grant = 1'b1;
    repeat (6) @(negedge clk);
    host_read(got, 0);
    chk("R11 byte resent whole", got, 8'hE2);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule